// File: doc/BRIEF.md
# Vector-Clock Transaction Debug Node

This debug node sits next to one bus master and watches the transfer requests that master issues. A run-time programmable trigger compares each request against an address, an address mask and a direction selection. A request that matches becomes a pending event. For each pending event the node asks for exclusive access to the shared global timing vector. Once access is granted, the node reads the global vector, increments its own field and writes the vector back, all in one cycle. The updated vector becomes the node's local timing vector.

The node then emits a trace record. The record holds the captured address, the captured direction and the new local vector. A downstream compressor or trace store consumes these records. Offline analysis can then order the records from all nodes by vector-clock causality rather than by wall-clock time.

The node can hold up to two events while it waits for a grant: one in the working slot and one in the skid slot. Any further match while both slots are full is dropped and raises a sticky overflow flag.

Top module: `dbgn_node`

## Requirements
- R1: While reset is asserted and after it is released, before any stimulus, `trc_valid_o`, `gtv_req_o`, `gtv_we_o` and `ovf_o` are 0, and `trc_vec_o` is all zeros.
- R2: A valid request matches the address condition when `((bus_addr_i ^ cfg_addr_i) & cfg_mask_i) == 0`. A mask bit of 0 makes that address bit don't-care.
- R3: Direction select `cfg_dir_i` works as follows. Bit 0 enables matching of reads (`bus_write_i`=0). Bit 1 enables matching of writes (`bus_write_i`=1). The value 2'b11 matches both directions and 2'b00 matches nothing.
- R4: A configuration written with `cfg_we_i` at a clock edge governs every request sampled from the next edge onward. The configuration resets to direction 2'b00.
- R5: `gtv_req_o` is high exactly while at least one event is pending. The vector is updated only in a cycle where both `gtv_req_o` and `gtv_gnt_i` are high, and `gtv_we_o` is high only in such a cycle.
- R6: In an update cycle, `gtv_wr_o` equals `gtv_rd_i` with field NODE_IDX incremented by one. Field k occupies bits [32k+31:32k], and every other field passes through unchanged.
- R7: Vector fields wrap modulo 2^32: a field holding 32'hFFFF_FFFF becomes 0.
- R8: One cycle after an update, `trc_valid_o` pulses for one cycle with the event's address and direction. At that point `trc_vec_o` equals the vector that was written, and it holds that value until the next update.
- R9: Up to two pending events are kept, and their traces come out in the order the events matched.
- R10: A match that arrives while two events are already held is dropped. It sets `ovf_o`, which then stays high until reset.
- R11: A request with `bus_valid_i` low never matches, whatever its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load trigger configuration |
| cfg_addr_i | input | ADDR_W | Trigger compare address |
| cfg_mask_i | input | ADDR_W | Trigger address mask, 1 = compare |
| cfg_dir_i | input | 2 | Direction enables: bit0 read, bit1 write |
| bus_valid_i | input | 1 | Master issues a request this cycle |
| bus_write_i | input | 1 | Request direction, 1 = write |
| bus_addr_i | input | ADDR_W | Request address |
| gtv_req_o | output | 1 | Request access to global vector |
| gtv_gnt_i | input | 1 | Access granted this cycle |
| gtv_rd_i | input | NODES*32 | Current global vector |
| gtv_we_o | output | 1 | Write global vector this cycle |
| gtv_wr_o | output | NODES*32 | Updated global vector |
| trc_valid_o | output | 1 | Trace record valid pulse |
| trc_write_o | output | 1 | Traced direction |
| trc_addr_o | output | ADDR_W | Traced address |
| trc_vec_o | output | NODES*32 | Local timing vector |
| ovf_o | output | 1 | Sticky event overflow |

## Verification
The trigger is exercised with requests whose addresses differ only in masked bits or only in compared bits, which separates mask handling from plain equality. Reads and writes are sent under each of the four direction settings, and requests with `bus_valid_i` low are sent as well. The global vector is changed in other nodes' fields between events, which shows that those fields pass through while only the own field advances; a field preset to its maximum shows the wrap. The grant is then withheld while three matches arrive back to back. This separates correct skid ordering from dropping the wrong event, and shows whether the overflow flag is raised and stays raised.

// File: rtl/dbgn_pkg.sv
package dbgn_pkg;
  localparam int FIELD_W = 32;
  localparam int DIR_RD  = 0;
  localparam int DIR_WR  = 1;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/dbgn_trigger.sv
module dbgn_trigger import dbgn_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic [1:0]        cfg_dir_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] addr_q, mask_q;
  logic [1:0]        dir_q;
  logic              dir_ok, addr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mask_q <= '0;
      dir_q  <= '0;
    end else if (cfg_we_i) begin
      addr_q <= cfg_addr_i;
      mask_q <= cfg_mask_i;
      dir_q  <= cfg_dir_i;
    end
  end

  always_comb begin
    dir_ok  = bus_write_i ? dir_q[DIR_WR] : dir_q[DIR_RD];
    addr_ok = ((bus_addr_i ^ addr_q) & mask_q) == '0;
    match_o = bus_valid_i && dir_ok && addr_ok;
  end

  // R11
  no_idle_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |-> !match_o);
  // R3
  write_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && bus_write_i) |-> dir_q[DIR_WR]);
endmodule

// File: rtl/dbgn_evq.sv
module dbgn_evq #(
  parameter int EV_W = 33
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_req_i,
  input  logic [EV_W-1:0] ev_i,
  input  logic            pop_i,
  output logic            pend_o,
  output logic [EV_W-1:0] head_o,
  output logic            ovf_o
);
  logic [EV_W-1:0] slot0_q, slot1_q;
  logic [1:0]      cnt_q;
  logic            full, push;

  assign full   = (cnt_q == 2'd2);
  assign push   = push_req_i && !full;
  assign pend_o = (cnt_q != 2'd0);
  assign head_o = slot0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot0_q <= '0;
      slot1_q <= '0;
      cnt_q   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (pop_i) slot0_q <= slot1_q;
      if (push) begin
        if (cnt_q == 2'd0 || (cnt_q == 2'd1 && pop_i)) slot0_q <= ev_i;
        else slot1_q <= ev_i;
      end
      case ({push, pop_i})
        2'b10:   cnt_q <= cnt_q + 2'd1;
        2'b01:   cnt_q <= cnt_q - 2'd1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_req_i && full) ovf_o <= 1'b1;
    end
  end

  // R9
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 2'd2);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R5
  pop_when_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> pend_o);
endmodule

// File: rtl/dbgn_vclk.sv
module dbgn_vclk import dbgn_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int NODES    = 5,
  parameter int NODE_IDX = 0,
  localparam int VEC_W   = NODES * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic [ADDR_W:0]   head_i,
  input  logic              gtv_gnt_i,
  input  logic [VEC_W-1:0]  gtv_rd_i,
  output logic              gtv_req_o,
  output logic              gtv_we_o,
  output logic [VEC_W-1:0]  gtv_wr_o,
  output logic              pop_o,
  output logic              trc_valid_o,
  output logic              trc_write_o,
  output logic [ADDR_W-1:0] trc_addr_o,
  output logic [VEC_W-1:0]  trc_vec_o
);
  assign gtv_req_o = pend_i;
  assign gtv_we_o  = pend_i && gtv_gnt_i;
  assign pop_o     = gtv_we_o;

  for (genvar k = 0; k < NODES; k++) begin : g_field
    if (k == NODE_IDX) begin : g_own
      assign gtv_wr_o[k*FIELD_W +: FIELD_W] = gtv_rd_i[k*FIELD_W +: FIELD_W] + field_t'(1);
    end else begin : g_pass
      assign gtv_wr_o[k*FIELD_W +: FIELD_W] = gtv_rd_i[k*FIELD_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trc_valid_o <= 1'b0;
      trc_write_o <= 1'b0;
      trc_addr_o  <= '0;
      trc_vec_o   <= '0;
    end else begin
      trc_valid_o <= gtv_we_o;
      if (gtv_we_o) begin
        trc_write_o <= head_i[ADDR_W];
        trc_addr_o  <= head_i[ADDR_W-1:0];
        trc_vec_o   <= gtv_wr_o;
      end
    end
  end

  // R8
  trace_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gtv_we_o |=> trc_valid_o);
  // R8
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(gtv_we_o) |-> $stable(trc_vec_o));
endmodule

// File: rtl/dbgn_node.sv
module dbgn_node import dbgn_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int NODES    = 5,
  parameter int NODE_IDX = 0,
  localparam int VEC_W   = NODES * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic [1:0]        cfg_dir_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              gtv_req_o,
  input  logic              gtv_gnt_i,
  input  logic [VEC_W-1:0]  gtv_rd_i,
  output logic              gtv_we_o,
  output logic [VEC_W-1:0]  gtv_wr_o,
  output logic              trc_valid_o,
  output logic              trc_write_o,
  output logic [ADDR_W-1:0] trc_addr_o,
  output logic [VEC_W-1:0]  trc_vec_o,
  output logic              ovf_o
);
  logic            match, pend, pop;
  logic [ADDR_W:0] head;

  dbgn_trigger #(.ADDR_W(ADDR_W)) u_trig (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_mask_i, .cfg_dir_i,
    .bus_valid_i, .bus_write_i, .bus_addr_i, .match_o(match)
  );

  dbgn_evq #(.EV_W(ADDR_W + 1)) u_evq (
    .clk_i, .rst_ni, .push_req_i(match), .ev_i({bus_write_i, bus_addr_i}),
    .pop_i(pop), .pend_o(pend), .head_o(head), .ovf_o
  );

  dbgn_vclk #(.ADDR_W(ADDR_W), .NODES(NODES), .NODE_IDX(NODE_IDX)) u_vclk (
    .clk_i, .rst_ni, .pend_i(pend), .head_i(head), .gtv_gnt_i, .gtv_rd_i,
    .gtv_req_o, .gtv_we_o, .gtv_wr_o, .pop_o(pop),
    .trc_valid_o, .trc_write_o, .trc_addr_o, .trc_vec_o
  );

  // R8
  trace_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o |-> trc_vec_o == $past(gtv_wr_o));
  // R5
  trace_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o |-> ($past(gtv_gnt_i) && $past(gtv_req_o)));
endmodule

// File: tb/dbgn_node_tb_top.sv
`timescale 1ns/1ps
module dbgn_node_tb_top;
  localparam int AW = 32;
  localparam int NN = 5;
  localparam int IDX = 2;
  localparam int VW = NN * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0, cfg_mask = '0;
  logic [1:0] cfg_dir = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic gnt_en = 1'b0;
  logic [VW-1:0] gv = '0;
  logic gtv_req, gtv_gnt, gtv_we, trc_valid, trc_write, ovf;
  logic [VW-1:0] gtv_wr, trc_vec;
  logic [AW-1:0] trc_addr;

  int checks = 0, fails = 0;
  logic [AW:0] ev_q[$];
  logic [VW-1:0] vec_q[$];
  logic [VW-1:0] last_vec = '0;

  always #2.5 clk = ~clk;
  assign gtv_gnt = gnt_en && gtv_req;

  dbgn_node #(.ADDR_W(AW), .NODES(NN), .NODE_IDX(IDX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_mask_i(cfg_mask), .cfg_dir_i(cfg_dir), .bus_valid_i(bus_valid),
    .bus_write_i(bus_write), .bus_addr_i(bus_addr), .gtv_req_o(gtv_req),
    .gtv_gnt_i(gtv_gnt), .gtv_rd_i(gv), .gtv_we_o(gtv_we), .gtv_wr_o(gtv_wr),
    .trc_valid_o(trc_valid), .trc_write_o(trc_write), .trc_addr_o(trc_addr),
    .trc_vec_o(trc_vec), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] bump(input logic [VW-1:0] v);
    logic [VW-1:0] r = v;
    r[IDX*32 +: 32] = v[IDX*32 +: 32] + 32'd1;
    return r;
  endfunction

  // global vector owner: applies only the bench's own prediction
  always @(posedge clk) if (gtv_req && gtv_gnt) gv <= bump(gv);

  // monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (gtv_req && gtv_gnt) begin
        chk(gtv_we == 1'b1, "R5", VW'(gtv_we), VW'(1));
        chk(gtv_wr == bump(gv), "R6/R7", gtv_wr, bump(gv));
        vec_q.push_back(bump(gv));
      end else if (gtv_we) begin
        chk(1'b0, "R5", VW'(gtv_we), VW'(0));
      end
      if (trc_valid) begin
        if (ev_q.size() == 0 || vec_q.size() == 0) begin
          chk(1'b0, "R8 unexpected trace", VW'(trc_addr), '0);
        end else begin
          logic [AW:0] e;
          logic [VW-1:0] v;
          e = ev_q.pop_front();
          v = vec_q.pop_front();
          chk({trc_write, trc_addr} == e, "R8/R9 event", VW'({trc_write, trc_addr}), VW'(e));
          chk(trc_vec == v, "R8 vector", trc_vec, v);
          last_vec = v;
        end
      end
    end
  end

  task automatic cfg(input logic [AW-1:0] a, input logic [AW-1:0] m, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_mask = m; cfg_dir = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input bit vld, input bit wr, input logic [AW-1:0] a, input bit exp);
    bus_valid = vld; bus_write = wr; bus_addr = a;
    if (exp) ev_q.push_back({wr, a});
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1;
    // R1 during reset
    chk(!trc_valid && !gtv_req && !gtv_we && !ovf && trc_vec == '0, "R1", trc_vec, '0);
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(!trc_valid && !gtv_req && !gtv_we && !ovf && trc_vec == '0, "R1", trc_vec, '0);
    // R4: reset direction 2'b00 matches nothing
    xfer(1, 1, 32'h0, 0);
    idle(3);
    chk(gtv_req == 1'b0, "R4 reset cfg", VW'(gtv_req), '0);

    gnt_en = 1'b1;
    // R2/R3: writes in 0x1000_xxxx
    cfg(32'h1000_0000, 32'hFFFF_0000, 2'b10);
    xfer(1, 1, 32'h1000_1234, 1);
    xfer(1, 0, 32'h1000_0000, 0);          // R3 read ignored
    xfer(1, 1, 32'h1001_0000, 0);          // R2 compared bit differs
    xfer(1, 1, 32'h1000_FFFF, 1);          // R2 masked bits differ
    xfer(0, 1, 32'h1000_0000, 0);          // R11 not valid
    idle(6);
    // R4: read-only takes effect on the very next request
    cfg(32'h0000_00A0, 32'h0000_00F0, 2'b01);
    xfer(1, 0, 32'h5555_55AB, 1);
    xfer(1, 1, 32'h0000_00A0, 0);
    idle(6);
    // R3 both directions, mask all don't-care
    cfg(32'h0, 32'h0, 2'b11);
    gv[0 +: 32] = 32'd7; gv[4*32 +: 32] = 32'd99;  // other nodes advanced
    xfer(1, 0, 32'hDEAD_BEEF, 1);
    idle(4);
    gv[1*32 +: 32] = 32'h1234;
    xfer(1, 1, 32'hCAFE_0000, 1);
    idle(6);
    // R7 wrap
    gv[IDX*32 +: 32] = 32'hFFFF_FFFF;
    xfer(1, 1, 32'h0000_0004, 1);
    idle(6);
    chk(trc_vec[IDX*32 +: 32] == 32'd0, "R7 wrap", trc_vec, '0);
    // R3 direction none
    cfg(32'h0, 32'h0, 2'b00);
    xfer(1, 1, 32'h0, 0);
    xfer(1, 0, 32'h0, 0);
    idle(4);
    chk(trc_vec == last_vec, "R8 hold", trc_vec, last_vec);
    // R9/R10 skid and overflow
    cfg(32'h0, 32'h0, 2'b11);
    gnt_en = 1'b0;
    chk(ovf == 1'b0, "R10 pre", VW'(ovf), '0);
    xfer(1, 1, 32'h0000_0A01, 1);
    xfer(1, 0, 32'h0000_0A02, 1);
    chk(ovf == 1'b0, "R10 two held", VW'(ovf), '0);
    xfer(1, 1, 32'h0000_0A03, 0);
    idle(3);
    chk(ovf == 1'b1, "R10 set", VW'(ovf), VW'(1));
    chk(gtv_req == 1'b1 && !trc_valid, "R5 wait grant", VW'(gtv_req), VW'(1));
    gnt_en = 1'b1;
    idle(8);
    chk(gtv_req == 1'b0, "R5 drained", VW'(gtv_req), '0);
    chk(ovf == 1'b1, "R10 sticky", VW'(ovf), VW'(1));
    chk(ev_q.size() == 0, "R9 all traced", VW'(ev_q.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule